// File: doc/BRIEF.md
# Pipelined Bus Cycle Memory Controller

This controller joins a 32-bit pipelined processor bus to a synchronous single-cycle-read SRAM that has separate read and write ports. In every bus cycle the processor drives an address phase: a two-bit cycle-type code, an address and a write flag. The data phase follows in the next cycle and ends when the controller holds its wait output low. Nonsequential cycles open a fresh access at the presented address. Sequential cycles continue the current burst one word further on, and the bus address is not decoded for them. Internal and coprocessor cycles leave memory untouched.

A nonsequential access is stretched by a fixed number of wait states, `WAIT_N` (0 to 3, default 1), to allow time for full address decoding. A sequential access always completes in one cycle. Reads are launched on the edge that accepts the address phase, so the SRAM's registered output is ready by the end of the data phase. Writes are committed on the last data-phase cycle, using the write data the processor drives during that phase. A read whose address phase coincides with a write commit to the same word receives the new data through a bypass.

Top module: `bus_cycle_memctl`

## Requirements
- R1: The code {cycNoReq, cycSeq} decodes as 00 nonsequential, 01 sequential, 10 internal and 11 coprocessor. An accepted nonsequential or sequential read raises memRdEn for exactly the one cycle whose closing edge accepts that address phase.
- R2: An accepted internal (10) or coprocessor (11) cycle raises neither memRdEn nor memWe, and the following cycle performs no memory access.
- R3: A nonsequential access uses busAddr with its two low bits cleared. memRdAddr and memWrAddr carry the word index, which is address bits [MEM_AW+1:2].
- R4: A sequential access uses the address of the last committed access plus 4 and ignores busAddr. This also holds when internal or coprocessor cycles come in between.
- R5: For a read, busRdata holds the word from memory during the final data-phase cycle, which is the first cycle after acceptance in which busWait is low.
- R6: busWait is high for exactly WAIT_N consecutive cycles, starting in the cycle right after a nonsequential address phase is accepted. A sequential access never raises busWait.
- R7: While busWait is high, the address-phase inputs and busWdata are not sampled: no memory strobe fires, and changing those inputs has no effect.
- R8: memWe pulses for exactly one cycle per committed write, in the final data-phase cycle. In that cycle memWrAddr is the access word index and memWdata equals busWdata.
- R9: During reset and right after it, busWait and memWe are low. The first address phase after reset is treated as nonsequential whatever its code.
- R10: A read accepted in the same cycle as a write commit to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycNoReq | input | 1 | Cycle-type high bit (1 = no memory request) |
| cycSeq | input | 1 | Cycle-type low bit (1 = sequential) |
| busAddr | input | ADDR_W | Address-phase byte address |
| busWrite | input | 1 | Address-phase write flag |
| busWdata | input | DATA_W | Write data, driven in the data phase |
| busRdata | output | DATA_W | Read data, valid in the final data-phase cycle |
| busWait | output | 1 | Stalls the processor while high |
| memRdEn | output | 1 | SRAM read enable |
| memRdAddr | output | MEM_AW | SRAM read word index |
| memRdata | input | DATA_W | SRAM registered read data |
| memWe | output | 1 | SRAM write enable |
| memWrAddr | output | MEM_AW | SRAM write word index |
| memWdata | output | DATA_W | SRAM write data |

## Verification
On every cycle, the embedded assertions check the following properties:
- The wait output rises only after an accepted nonsequential phase and never stays high longer than WAIT_N cycles.
- No strobe fires during a stall.
- Write commits happen only with wait low.
- Idle codes are never followed by a write.
- The latched address is either the aligned bus address or the previous address plus four.

The bench's scenarios cover the remaining behaviour, which the assertions cannot see:
- Read data values.
- The bypass on a read-after-write to the same word.
- Burst continuation across internal cycles.
- Insensitivity to garbage driven during stalls.
- The reset override of the first code.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

  typedef enum logic [1:0] {
    CYC_NONSEQ   = 2'b00,
    CYC_SEQ      = 2'b01,
    CYC_INTERNAL = 2'b10,
    CYC_COPROC   = 2'b11
  } cycKind_e;

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic takeNew;   // accept a fresh (nonsequential) address this edge
    logic takeSeq;   // accept a sequential continuation this edge
    logic rdIssue;   // launch an SRAM read this edge
    logic wrCommit;  // commit a write this edge
  } ctlStrobes_t;

endpackage

// File: rtl/memctl_ctrl.sv
module memctl_ctrl
  import memctl_pkg::*;
#(
  parameter int WAIT_N = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycNoReq,
  input  logic        cycSeq,
  input  logic        busWrite,
  output ctlStrobes_t stb,
  output logic        busWait
);

  localparam int WCW = (WAIT_N > 0) ? $clog2(WAIT_N + 1) : 1;
  localparam logic [WCW-1:0] WAIT_LOAD = WCW'(WAIT_N);

  cycKind_e       kind;
  logic           firstCyc;
  logic           dpValid;
  logic           dpWrite;
  logic [WCW-1:0] waitCnt;
  logic           accept;
  logic           isNew;
  logic           isAcc;

  assign kind = cycKind_e'({cycNoReq, cycSeq});

  always_comb begin
    busWait      = dpValid && (waitCnt != '0);
    accept       = !busWait;
    isNew        = firstCyc || (kind == CYC_NONSEQ);
    isAcc        = isNew || (kind == CYC_SEQ);
    stb.takeNew  = accept && isNew;
    stb.takeSeq  = accept && !firstCyc && (kind == CYC_SEQ);
    stb.rdIssue  = accept && isAcc && !busWrite;
    stb.wrCommit = dpValid && dpWrite && (waitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstCyc <= 1'b1;
      dpValid  <= 1'b0;
      dpWrite  <= 1'b0;
      waitCnt  <= '0;
    end else if (accept) begin
      firstCyc <= 1'b0;
      dpValid  <= isAcc;
      dpWrite  <= busWrite;
      waitCnt  <= isNew ? WAIT_LOAD : '0;
    end else begin
      waitCnt  <= waitCnt - 1'b1;
    end
  end

  // Length of the current stall run, for the bound check.
  logic [3:0] waitRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        waitRun <= '0;
    else if (busWait) waitRun <= waitRun + 1'b1;
    else              waitRun <= '0;
  end

  p_wait_after_new_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWait) |-> $past(stb.takeNew));

  p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWait |-> (int'(waitRun) < WAIT_N));

  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    busWait |-> !(stb.rdIssue || stb.takeNew || stb.takeSeq || stb.wrCommit));

  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !firstCyc && cycNoReq) |=> !stb.wrCommit);

  p_write_unstalled_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCommit |-> !busWait);

endmodule

// File: rtl/memctl_datapath.sv
module memctl_datapath
  import memctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memRdAddr,
  output logic              memWe,
  output logic [MEM_AW-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int LSB = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(STEP - ADDR_W'(1));

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic              byHit;
  logic [DATA_W-1:0] byData;
  logic              sameWord;

  always_comb begin
    nextAddr = stb.takeNew ? (busAddr & ALIGN_MASK) : (curAddr + STEP);
    sameWord = (nextAddr[MEM_AW+LSB-1:LSB] == curAddr[MEM_AW+LSB-1:LSB]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      byHit   <= 1'b0;
      byData  <= '0;
    end else begin
      if (stb.takeNew || stb.takeSeq) curAddr <= nextAddr;
      if (stb.rdIssue) begin
        byHit  <= stb.wrCommit && sameWord;
        byData <= busWdata;
      end
    end
  end

  assign memRdEn   = stb.rdIssue;
  assign memRdAddr = nextAddr[MEM_AW+LSB-1:LSB];
  assign memWe     = stb.wrCommit;
  assign memWrAddr = curAddr[MEM_AW+LSB-1:LSB];
  assign memWdata  = busWdata;
  assign busRdata  = byHit ? byData : memRdata;

  p_new_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeNew |=> (curAddr == ($past(busAddr) & ALIGN_MASK)));

  p_seq_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeSeq |=> (curAddr == $past(curAddr) + STEP));

  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.takeNew || stb.takeSeq) |=> $stable(curAddr));

endmodule

// File: rtl/bus_cycle_memctl.sv
module bus_cycle_memctl
  import memctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10,
  parameter int WAIT_N = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycNoReq,
  input  logic              cycSeq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busWait,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  output logic [MEM_AW-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWdata
);

  ctlStrobes_t stb;

  memctl_ctrl #(.WAIT_N(WAIT_N)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cycNoReq (cycNoReq),
    .cycSeq   (cycSeq),
    .busWrite (busWrite),
    .stb      (stb),
    .busWait  (busWait)
  );

  memctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .memRdata  (memRdata),
    .busRdata  (busRdata),
    .memRdEn   (memRdEn),
    .memRdAddr (memRdAddr),
    .memWe     (memWe),
    .memWrAddr (memWrAddr),
    .memWdata  (memWdata)
  );

  p_no_we_in_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !busWait);

endmodule

// File: tb/bus_cycle_memctl_tb_top.sv
module bus_cycle_memctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 10;
  localparam int WAITS  = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycNoReq = 1'b1, cycSeq = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busWait;
  logic        memRdEn;
  logic [MEM_AW-1:0] memRdAddr;
  logic [31:0] memRdata = '0;
  logic        memWe;
  logic [MEM_AW-1:0] memWrAddr;
  logic [31:0] memWdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_memctl #(.MEM_AW(MEM_AW), .WAIT_N(WAITS)) dut_i (
    .clk(clk), .rstN(rstN), .cycNoReq(cycNoReq), .cycSeq(cycSeq),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .busRdata(busRdata), .busWait(busWait), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdata(memRdata), .memWe(memWe),
    .memWrAddr(memWrAddr), .memWdata(memWdata)
  );

  function automatic logic [31:0] initWord(int idx);
    return 32'hA500_0000 ^ (32'(idx) * 32'h0001_0003);
  endfunction

  // Behavioural SRAM attached to the design.
  logic [31:0] sram [int];
  always @(posedge clk) begin
    if (memRdEn)
      memRdata <= sram.exists(int'(memRdAddr)) ? sram[int'(memRdAddr)] : initWord(int'(memRdAddr));
    if (memWe) sram[int'(memWrAddr)] = memWdata;
  end

  // Stimulus queue and reference model state.
  typedef struct {
    logic [1:0]  code;
    logic [31:0] addr;
    bit          wr;
    logic [31:0] wd;
  } op_t;
  op_t opQ[$];

  int checks = 0, failures = 0;
  bit done = 0, garble = 0;
  bit rFirst, rDp, rDpWr, rDpByp;
  int rWait;
  logic [31:0] rDpAddr, rDpWd, rPrev;
  logic [31:0] refMem [int];

  function automatic int wIdx(logic [31:0] a);
    return int'(a[MEM_AW+1:2]);
  endfunction

  function automatic logic [31:0] refVal(int idx);
    return refMem.exists(idx) ? refMem[idx] : initWord(idx);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [1:0] c, logic [31:0] a, bit w, logic [31:0] d);
    op_t o;
    o.code = c; o.addr = a; o.wr = w; o.wd = d;
    opQ.push_back(o);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cycNoReq = 1'b1; cycSeq = 1'b0; busWrite = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(busWait === 1'b0, "R9", "busWait in reset", {31'b0, busWait}, 32'h0);
      chk(memWe === 1'b0, "R9", "memWe in reset", {31'b0, memWe}, 32'h0);
    end
    @(posedge clk);
    #1;
    rstN = 1'b1;
    rFirst = 1; rDp = 0; rDpWr = 0; rDpByp = 0; rWait = 0;
    rDpAddr = '0; rDpWd = '0; rPrev = '0;
  endtask

  task automatic cycle();
    op_t cur;
    bit inWait, expWe, accept, isNew, isAcc, expRd, byp;
    logic [31:0] nAddr;
    string tag;
    @(negedge clk);
    if (opQ.size() > 0) cur = opQ[0];
    else begin cur.code = 2'b10; cur.addr = 32'h0000_DEA0; cur.wr = 0; cur.wd = '0; end
    inWait = rDp && (rWait > 0);
    if (inWait && garble) begin
      cycNoReq = 1'b0; cycSeq = 1'b0; busAddr = 32'hFFFF_FFF0;
      busWrite = ~cur.wr; busWdata = 32'hBAD0_BAD0;
    end else begin
      cycNoReq = cur.code[1]; cycSeq = cur.code[0];
      busAddr = cur.addr; busWrite = cur.wr;
      busWdata = (rDp && rDpWr) ? rDpWd : 32'h0BAD_F00D;
    end
    #1;
    expWe = rDp && rDpWr && (rWait == 0);
    chk(busWait === inWait, "R6", "busWait", {31'b0, busWait}, {31'b0, inWait});
    chk(memWe === expWe, "R8", "memWe", {31'b0, memWe}, {31'b0, expWe});
    if (expWe) begin
      chk(int'(memWrAddr) == wIdx(rDpAddr), "R8", "memWrAddr", 32'(memWrAddr), 32'(wIdx(rDpAddr)));
      chk(memWdata === rDpWd, "R8", "memWdata", memWdata, rDpWd);
    end
    if (rDp && !rDpWr && rWait == 0)
      chk(busRdata === refVal(wIdx(rDpAddr)), rDpByp ? "R10" : "R5", "busRdata",
          busRdata, refVal(wIdx(rDpAddr)));
    accept = !inWait;
    isNew  = rFirst || (cur.code == 2'b00);
    isAcc  = isNew || (cur.code == 2'b01);
    expRd  = accept && isAcc && !cur.wr;
    tag = inWait ? "R7" : rFirst ? "R9" : (cur.code[1] ? "R2" : "R1");
    chk(memRdEn === expRd, tag, "memRdEn", {31'b0, memRdEn}, {31'b0, expRd});
    nAddr = isNew ? {cur.addr[31:2], 2'b00} : rPrev + 32'd4;
    if (expRd)
      chk(int'(memRdAddr) == wIdx(nAddr), rFirst ? "R9" : (isNew ? "R3" : "R4"),
          "memRdAddr", 32'(memRdAddr), 32'(wIdx(nAddr)));
    // advance the model across the coming edge
    byp = expWe && !cur.wr && (wIdx(nAddr) == wIdx(rDpAddr));
    if (expWe) refMem[wIdx(rDpAddr)] = rDpWd;
    if (accept) begin
      rFirst = 0;
      if (isAcc) begin
        rDp = 1; rDpWr = cur.wr; rDpAddr = nAddr; rDpWd = cur.wd;
        rWait = isNew ? WAITS : 0; rDpByp = byp; rPrev = nAddr;
      end else begin
        rDp = 0;
      end
      if (opQ.size() > 0) void'(opQ.pop_front());
    end else begin
      rWait--;
    end
  endtask

  task automatic runQueue();
    while (opQ.size() > 0) cycle();
    repeat (3) cycle();
  endtask

  initial begin
    doReset();
    // R9: sequential code first after reset acts as nonsequential
    push(2'b01, 32'h0000_0104, 0, 0);
    push(2'b00, 32'h0000_0040, 1, 32'h1111_AAAA);
    push(2'b01, 32'h0000_0000, 1, 32'h2222_BBBB);
    push(2'b01, 32'h0000_0000, 1, 32'h3333_CCCC);
    push(2'b10, 32'h0000_0000, 0, 0);          // R2 internal
    push(2'b11, 32'h0000_0000, 1, 32'hDEAD_DEAD); // R2 coprocessor
    push(2'b01, 32'h0000_0777, 0, 0);          // R4 continues at 0x4C
    push(2'b00, 32'h0000_0040, 0, 0);          // R5 reads written word
    push(2'b01, 32'h0000_0000, 0, 0);
    push(2'b00, 32'h0000_0200, 1, 32'h4444_DDDD);
    push(2'b00, 32'h0000_0200, 0, 0);          // R10 bypass
    push(2'b00, 32'h0000_0203, 0, 0);          // R3 alignment
    push(2'b01, 32'h0000_0999, 0, 0);
    push(2'b10, 32'h0000_0000, 0, 0);
    push(2'b10, 32'h0000_0000, 0, 0);
    push(2'b01, 32'h0000_0000, 1, 32'h5555_EEEE);
    push(2'b00, 32'h0000_0208, 0, 0);
    push(2'b00, 32'h0000_0300, 0, 0);
    push(2'b00, 32'h0000_0304, 0, 0);
    runQueue();
    // mid-stall reset, then garbage driven during stalls (R7)
    push(2'b00, 32'h0000_0500, 0, 0);
    cycle(); cycle();
    opQ.delete();
    doReset();
    garble = 1;
    push(2'b10, 32'h0000_0300, 1, 32'h6666_1234); // R9 internal code first
    push(2'b01, 32'h0000_0000, 0, 0);
    push(2'b00, 32'h0000_0300, 0, 0);
    push(2'b00, 32'h0000_0010, 1, 32'h7777_5678);
    push(2'b01, 32'h0000_0000, 1, 32'h8888_9ABC);
    push(2'b00, 32'h0000_0014, 0, 0);          // R10 bypass after seq write
    push(2'b11, 32'h0000_0000, 0, 0);
    push(2'b01, 32'h0000_0000, 0, 0);
    push(2'b00, 32'h0000_0010, 0, 0);
    runQueue();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule